// File: doc/BRIEF.md
# Descriptor Staging and Commit Port

This block sits between a 32-bit register write bus and the descriptor queue of a scatter-gather transfer engine. Software builds one transfer descriptor of eight 32-bit words by writing them one at a time. Seven words are held in staging registers. The eighth word is the control word, and writing it with its go bit set pushes the whole 256-bit descriptor into an internal FIFO as one entry. A write of any single word never exposes a half-built descriptor to the consumer.

The FIFO feeds the read and write data movers through a valid/ready output port. The block also reports a full flag, which software polls before it commits, an empty flag, and a level word whose two 16-bit halves give the queue occupancy as seen by the write side and by the read side. A commit that arrives while the queue is full is discarded and raises a sticky overflow flag. The staged words are left in place, so a series of similar descriptors needs only the changed words rewritten before each commit.

Top module: `desc_commit_port`

## Requirements
- R1: After reset the queue is empty: `fifo_empty`=1, `fifo_full`=0, `desc_valid`=0, `fill_level`=0 and `overflow`=0.
- R2: A write to word index 0 to 6 only updates that staged word; the queue level and outputs do not change.
- R3: A write to word index 7 with bit 31 set, while the queue is not full, appends one entry whose bits 32k+31:32k hold staged word k for k=0..6 and whose bits 255:224 hold the control value written in that same cycle.
- R4: A write to word index 7 with bit 31 clear pushes nothing; the queue level stays the same.
- R5: Staged words survive a commit; a second commit without rewriting them carries the same words 0 to 6.
- R6: Entries leave in the order they were committed; `desc_valid` is 1 exactly when the queue holds an entry, and an entry is removed on a clock edge where `desc_valid` and `desc_ready` are both 1.
- R7: `fifo_full` is 1 exactly when the queue holds DEPTH entries; a commit while full is dropped, leaving the level and head entry unchanged, and sets `overflow`.
- R8: `fill_level` bits 31:16 (write side) and bits 15:0 (read side) both equal the number of queued entries.
- R9: A commit and a removal in the same cycle both take effect when the queue is not full (level unchanged); when the queue is full the commit is dropped even though an entry leaves in that cycle.
- R10: `overflow` stays at 1 until reset, whatever later writes and removals occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_addr | input | 3 | Descriptor word index (7 is the control word) |
| bus_wr_data | input | 32 | Write data; bit 31 of the control word is the go bit |
| desc_valid | output | 1 | Head entry of the queue is available |
| desc_ready | input | 1 | Consumer takes the head entry |
| desc_data | output | 256 | Head descriptor, word k at bits 32k+31:32k |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_empty | output | 1 | Queue holds no entry |
| fill_level | output | 32 | Occupancy, write side in 31:16, read side in 15:0 |
| overflow | output | 1 | Sticky: a commit was dropped on a full queue |

## Verification
The two functions that can coincide are a commit from the bus and a removal by the consumer. The bench forces them into the same cycle on purpose, once with a partly filled queue and once with a full one, and random stimulus with a biased go bit and random ready produces many more such collisions. Each is judged against a bench model of the queue: with room the level must stay the same while the head advances and the new entry lands at the tail; when full the level must drop by one and the overflow flag must rise.

// File: rtl/desc_commit_pkg.sv
package desc_commit_pkg;

   localparam int DFLT_WORD_W  = 32;
   localparam int DFLT_N_WORDS = 8;
   localparam int DFLT_DEPTH   = 8;
   localparam int DFLT_LVL_W   = 16;

   // outcome of a control-word write in one cycle
   typedef enum logic [1:0] {
      CMT_NONE = 2'd0,
      CMT_PUSH = 2'd1,
      CMT_DROP = 2'd2
   } commit_e;

endpackage

// File: rtl/desc_stage_regs.sv
module desc_stage_regs #(
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 8,
   parameter int ADDR_W  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [WORD_W-1:0]         wr_data,
   output logic [WORD_W*N_WORDS-1:0] entry_o,
   output logic                      ctrl_hit_o
);

   localparam int LAST = N_WORDS - 1;

   // one holding register per non-control word
   for (genvar w = 0; w < LAST; w++) begin : g_word
      logic [WORD_W-1:0] held_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            held_q <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(w)))
            held_q <= wr_data;
      end

      assign entry_o[w*WORD_W +: WORD_W] = held_q;
   end

   // control word comes straight from the bus in the commit cycle
   assign entry_o[LAST*WORD_W +: WORD_W] = wr_data;
   assign ctrl_hit_o = wr_en && (wr_addr == ADDR_W'(LAST));

endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
   parameter  int WIDTH = 256,
   parameter  int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] dout_o,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o,
   output logic             empty_o
);

   logic [WIDTH-1:0] store_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
   logic [CNT_W-1:0] cnt_q;
   logic             push_ok, pop_ok;

   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;

   // pointer advance: free wrap for power-of-two depth, compare otherwise
   if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_ptr_nx = wr_ptr_q + 1'b1;
      assign rd_ptr_nx = rd_ptr_q + 1'b1;
   end else begin : g_wrap
      assign wr_ptr_nx = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_nx = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok)
         store_q[wr_ptr_q] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_ok)
            wr_ptr_q <= wr_ptr_nx;
         if (pop_ok)
            rd_ptr_q <= rd_ptr_nx;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout_o  = store_q[rd_ptr_q];
   assign count_o = cnt_q;

endmodule

// File: rtl/desc_commit_port.sv
module desc_commit_port
   import desc_commit_pkg::*;
#(
   parameter  int WORD_W  = DFLT_WORD_W,
   parameter  int N_WORDS = DFLT_N_WORDS,
   parameter  int DEPTH   = DFLT_DEPTH,
   parameter  int LVL_W   = DFLT_LVL_W,
   localparam int ADDR_W  = $clog2(N_WORDS),
   localparam int DESC_W  = WORD_W * N_WORDS,
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr_en,
   input  logic [ADDR_W-1:0]  bus_wr_addr,
   input  logic [WORD_W-1:0]  bus_wr_data,
   output logic               desc_valid,
   input  logic               desc_ready,
   output logic [DESC_W-1:0]  desc_data,
   output logic               fifo_full,
   output logic               fifo_empty,
   output logic [2*LVL_W-1:0] fill_level,
   output logic               overflow
);

   // elaboration-time parameter checks
   if (N_WORDS < 2) begin : g_bad_words
      $error("N_WORDS must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (CNT_W > LVL_W) begin : g_bad_lvl
      $error("LVL_W too narrow for DEPTH");
   end

   logic [DESC_W-1:0] staged_entry;
   logic              ctrl_hit;
   logic [CNT_W-1:0]  occ;
   commit_e           outcome;
   logic              ovf_q;

   desc_stage_regs #(
      .WORD_W  (WORD_W),
      .N_WORDS (N_WORDS),
      .ADDR_W  (ADDR_W)
   ) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr_en),
      .wr_addr    (bus_wr_addr),
      .wr_data    (bus_wr_data),
      .entry_o    (staged_entry),
      .ctrl_hit_o (ctrl_hit)
   );

   // go bit is the top bit of the control word; fullness judged before any pop
   always_comb begin
      outcome = CMT_NONE;
      if (ctrl_hit && bus_wr_data[WORD_W-1])
         outcome = fifo_full ? CMT_DROP : CMT_PUSH;
   end

   desc_fifo #(
      .WIDTH (DESC_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (outcome == CMT_PUSH),
      .din_i   (staged_entry),
      .pop_i   (desc_ready),
      .dout_o  (desc_data),
      .count_o (occ),
      .full_o  (fifo_full),
      .empty_o (fifo_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (outcome == CMT_DROP)
         ovf_q <= 1'b1;
   end

   assign overflow   = ovf_q;
   assign desc_valid = !fifo_empty;
   assign fill_level = {LVL_W'(occ), LVL_W'(occ)};

endmodule

// File: rtl/desc_commit_port_chk.sv
module desc_commit_port_chk #(
   parameter int ADDR_W = 3,
   parameter int LVL_W  = 16,
   parameter int LAST   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic               go_bit,
   input logic               valid,
   input logic               ready,
   input logic               full,
   input logic               empty,
   input logic [2*LVL_W-1:0] level,
   input logic               ovf
);

   logic ctrl_wr;
   logic taken;
   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(LAST));
   assign taken   = valid && ready;

   // R1 / R7: full and empty never together
   assert_full_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   // R8: both halves of the level word agree
   assert_level_halves_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level[2*LVL_W-1:LVL_W] == level[LVL_W-1:0]);

   // R6: valid tracks a non-empty queue
   assert_valid_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid == !empty);

   // R4: go-clear control write with no removal leaves the level alone
   assert_nogo_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !go_bit && !taken) |=> $stable(level));

   // R3: accepted commit without removal raises the level by one
   assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && go_bit && !full && !taken) |=>
         (level[LVL_W-1:0] == $past(level[LVL_W-1:0]) + 1'b1));

   // R7: full with no removal stays full and flags overflow on a commit
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ctrl_wr && go_bit && !taken) |=> (full && ovf));

   // R9: commit and removal together while full lowers the level by one
   assert_full_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ctrl_wr && go_bit && taken) |=>
         (level[LVL_W-1:0] == $past(level[LVL_W-1:0]) - 1'b1));

   // R10: overflow is sticky
   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

endmodule

bind desc_commit_port desc_commit_port_chk #(
   .ADDR_W (ADDR_W),
   .LVL_W  (LVL_W),
   .LAST   (N_WORDS - 1)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (bus_wr_en),
   .wr_addr (bus_wr_addr),
   .go_bit  (bus_wr_data[WORD_W-1]),
   .valid   (desc_valid),
   .ready   (desc_ready),
   .full    (fifo_full),
   .empty   (fifo_empty),
   .level   (fill_level),
   .ovf     (overflow)
);

// File: tb/desc_commit_port_tb.sv
`timescale 1ns/1ps
module desc_commit_port_tb;

   localparam int DEPTH = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr_en = 1'b0;
   logic [2:0]   bus_wr_addr = '0;
   logic [31:0]  bus_wr_data = '0;
   logic         desc_valid;
   logic         desc_ready = 1'b0;
   logic [255:0] desc_data;
   logic         fifo_full;
   logic         fifo_empty;
   logic [31:0]  fill_level;
   logic         overflow;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [255:0] mq[$];
   logic [31:0]  m_stage [7];
   logic         m_ovf = 1'b0;

   always #2 clk = ~clk;

   desc_commit_port #(.DEPTH(DEPTH)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr_en   (bus_wr_en),
      .bus_wr_addr (bus_wr_addr),
      .bus_wr_data (bus_wr_data),
      .desc_valid  (desc_valid),
      .desc_ready  (desc_ready),
      .desc_data   (desc_data),
      .fifo_full   (fifo_full),
      .fifo_empty  (fifo_empty),
      .fill_level  (fill_level),
      .overflow    (overflow)
   );

   task automatic chk(input string tag, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [255:0] build_entry(input logic [31:0] ctrl);
      logic [255:0] e;
      for (int k = 0; k < 7; k++) e[32*k +: 32] = m_stage[k];
      e[255:224] = ctrl;
      return e;
   endfunction

   // one bus cycle: drive, check current state, then advance the model
   task automatic step(input logic en, input logic [2:0] a, input logic [31:0] d,
                       input logic rdy, input string tag);
      bit pop, go, was_full;
      @(negedge clk);
      bus_wr_en = en; bus_wr_addr = a; bus_wr_data = d; desc_ready = rdy;
      #1;
      chk(tag,  "level_rd", 256'(fill_level[15:0]), 256'(mq.size()));
      chk("R8", "level_wr", 256'(fill_level[31:16]), 256'(mq.size()));
      chk(tag,  "full",     256'(fifo_full), 256'(mq.size() == DEPTH));
      chk(tag,  "empty",    256'(fifo_empty), 256'(mq.size() == 0));
      chk(tag,  "valid",    256'(desc_valid), 256'(mq.size() != 0));
      chk(tag,  "overflow", 256'(overflow), 256'(m_ovf));
      if (mq.size() != 0) chk(tag, "head", desc_data, mq[0]);
      pop      = rdy && (mq.size() != 0);
      go       = en && (a == 3'd7) && d[31];
      was_full = (mq.size() == DEPTH);
      if (go && was_full) m_ovf = 1'b1;
      if (pop) void'(mq.pop_front());
      if (go && !was_full) mq.push_back(build_entry(d));
      if (en && a != 3'd7) m_stage[a] = d;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R6 watchdog act=running exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < 7; k++) m_stage[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      step(0, 0, 0, 0, "R1");
      step(0, 0, 0, 1, "R1");

      // R2: stage words, no queue effect
      for (int k = 0; k < 7; k++) step(1, 3'(k), 32'h1100_0000 + 32'(k * 17), 0, "R2");
      step(0, 0, 0, 0, "R2");

      // R4: control write without go
      step(1, 7, 32'h0000_4321, 0, "R4");
      step(0, 0, 0, 0, "R4");

      // R3: commit
      step(1, 7, 32'h8000_0301, 0, "R3");
      step(0, 0, 0, 0, "R3");

      // R5: commit again reusing staged words
      step(1, 7, 32'h8000_0302, 0, "R5");
      step(0, 0, 0, 0, "R5");
      step(1, 2, 32'hDEAD_0002, 0, "R5");
      step(1, 7, 32'h8100_0303, 0, "R5");

      // R6: drain in order
      for (int k = 0; k < 4; k++) step(0, 0, 0, 1, "R6");

      // R7: fill, then commit while full
      for (int k = 0; k < DEPTH; k++) step(1, 7, 32'h8000_1000 + 32'(k), 0, "R7");
      step(0, 0, 0, 0, "R7");
      step(1, 7, 32'h8000_BAD0, 0, "R7");
      step(0, 0, 0, 0, "R7");

      // R9: commit while full with a removal in the same cycle
      step(1, 7, 32'h8000_BAD1, 1, "R9");
      step(0, 0, 0, 0, "R9");
      // R9: commit with removal when not full
      step(1, 7, 32'h8000_2001, 1, "R9");
      step(1, 7, 32'h8000_2002, 1, "R9");
      step(0, 0, 0, 0, "R9");

      // R10: overflow stays through a full drain
      for (int k = 0; k < DEPTH + 2; k++) step(0, 0, 0, 1, "R10");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [2:0]  a;
         logic [31:0] d;
         a = ($urandom % 3 == 0) ? 3'd7 : 3'($urandom);
         d = $urandom;
         if (a == 3'd7 && ($urandom % 4 != 0)) d[31] = 1'b1;
         step(1'($urandom), a, d, ($urandom % 3 != 0), "R6");
      end
      step(0, 0, 0, 0, "R6");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule